// File: doc/BRIEF.md
# Width-Parameterised Eight-Function ALU

This block is an arithmetic-logic unit. It takes two operands of a width set by a parameter and a three-bit function code, and returns a result of the same width along with a carry flag and a zero flag. Four of the eight codes select arithmetic: the sum, the difference, and an increment of either operand. The other four select bitwise logic. One shared adder serves all the arithmetic. A small multiplexer picks between the adder and the logic unit.

The datapath is combinational. By default a single output register captures the result and the flags whenever the input strobe is high, and it raises an output strobe one cycle later. This lets a surrounding pipeline, or a bench, consume one result per clock. Setting the register parameter to zero removes the register, and the outputs then follow the inputs directly.

Top module: `opsel_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `res`, `carry`, `zero` and `out_vld` are all cleared to 0 on that edge. Note that `zero` is cleared to 0 even though `res` is 0.
- R2: Code 3'b000 gives `res` = (opa + opb) mod 2^W. `carry` is the carry out of bit W-1.
- R3: Code 3'b001 gives `res` = (opa - opb) mod 2^W. `carry` is 1 exactly when opa >= opb, read as unsigned values (the inverted borrow).
- R4: Code 3'b010 gives `res` = (opa + 1) mod 2^W, and code 3'b011 gives `res` = (opb + 1) mod 2^W. For both, `carry` is 1 exactly when the incremented operand was all ones.
- R5: Code 3'b100 gives `res` = opa AND opb, and code 3'b101 gives `res` = opa OR opb. For both, `carry` is 0.
- R6: Code 3'b110 gives `res` = opa XOR opb, and code 3'b111 gives `res` = NOT opa. For both, `carry` is 0.
- R7: Whenever a result is captured, `zero` is 1 exactly when every bit of the captured `res` is 0.
- R8: `res`, `carry` and `zero` are loaded on the rising edge where `in_vld` is 1. `out_vld` equals the value `in_vld` had at the previous edge, so it is high for exactly one cycle per accepted operation.
- R9: At an edge where `in_vld` is 0, `res`, `carry` and `zero` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands and function code are valid this cycle |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| fsel | input | 3 | Function code |
| res | output | W | Result |
| carry | output | 1 | Carry, or inverted borrow for subtraction |
| zero | output | 1 | Result is all zeros |
| out_vld | output | 1 | Result and flags are new this cycle |

## Verification
The cases that are hardest to reach at random are the boundaries of the carry and zero flags. These are a sum that wraps to exactly zero, a subtraction of equal operands (carry high and zero high together), and an increment of an all-ones operand. Random operands almost never produce them. A directed prologue therefore drives these operand pairs for every function code. Random traffic follows, with gaps in the strobe and one reset in the middle of the run, and a behavioural model is compared against the outputs on every clock. The gaps check that the outputs hold their values, and the mid-run reset checks that the flags clear while operations are in flight.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_SUB  = 3'b001,
    FN_INCA = 3'b010,
    FN_INCB = 3'b011,
    FN_AND  = 3'b100,
    FN_OR   = 3'b101,
    FN_XOR  = 3'b110,
    FN_NOTA = 3'b111
  } alu_fn_e;

  localparam int FN_W = 3;

  // the top bit of the code splits arithmetic from logic
  function automatic logic fn_is_logic(input logic [FN_W-1:0] fn);
    return fn[FN_W-1];
  endfunction

endpackage

// File: rtl/opsel_alu_arith.sv
module opsel_alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sub_fn,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int EW = W + 1;

  logic [W-1:0] x, y;
  logic         cin;
  logic [EW-1:0] wide;

  // one adder: operand steering and carry-in select the operation
  always_comb begin
    case (sub_fn)
      2'b00:   begin x = a; y = b;       cin = 1'b0; end
      2'b01:   begin x = a; y = ~b;      cin = 1'b1; end
      2'b10:   begin x = a; y = '0;      cin = 1'b1; end
      default: begin x = b; y = '0;      cin = 1'b1; end
    endcase
  end

  assign wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum  = wide[W-1:0];
  assign cout = wide[W];

endmodule

// File: rtl/opsel_alu_logic.sv
module opsel_alu_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sub_fn,
  output logic [W-1:0] y
);
  always_comb begin
    case (sub_fn)
      2'b00:   y = a & b;
      2'b01:   y = a | b;
      2'b10:   y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/opsel_alu_outreg.sv
module opsel_alu_outreg #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_vld,
  input  logic [W-1:0] d_res,
  input  logic         d_carry,
  input  logic         d_zero,
  output logic [W-1:0] q_res,
  output logic         q_carry,
  output logic         q_zero,
  output logic         q_vld
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          q_res   <= '0;
          q_carry <= 1'b0;
          q_zero  <= 1'b0;
          q_vld   <= 1'b0;
        end else begin
          q_vld <= d_vld;
          if (d_vld) begin
            q_res   <= d_res;
            q_carry <= d_carry;
            q_zero  <= d_zero;
          end
        end
      end
    end else begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      assign q_res   = d_res;
      assign q_carry = d_carry;
      assign q_zero  = d_zero;
      assign q_vld   = d_vld;
    end
  endgenerate
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   fsel,
  output logic [W-1:0] res,
  output logic         carry,
  output logic         zero,
  output logic         out_vld
);
  import opsel_alu_pkg::*;

  logic [W-1:0] arith_y, logic_y, res_c;
  logic         arith_c, carry_c, zero_c, is_log;

  opsel_alu_arith #(.W(W)) u_arith (
    .a(opa), .b(opb), .sub_fn(fsel[1:0]), .sum(arith_y), .cout(arith_c)
  );

  opsel_alu_logic #(.W(W)) u_logic (
    .a(opa), .b(opb), .sub_fn(fsel[1:0]), .y(logic_y)
  );

  assign is_log  = fn_is_logic(fsel);
  assign res_c   = is_log ? logic_y : arith_y;
  assign carry_c = is_log ? 1'b0 : arith_c;
  assign zero_c  = ~|res_c;

  opsel_alu_outreg #(.W(W), .REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst(rst), .d_vld(in_vld),
    .d_res(res_c), .d_carry(carry_c), .d_zero(zero_c),
    .q_res(res), .q_carry(carry), .q_zero(zero), .q_vld(out_vld)
  );

endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_vld,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [2:0]   fsel,
  input logic [W-1:0] res,
  input logic         carry,
  input logic         zero,
  input logic         out_vld
);
  generate
    if (REG_OUT) begin : g_chk
      // R8
      vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
      // R8
      vld_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
      // R9
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(res) && $stable(carry) && $stable(zero)));
      // R7
      zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (zero == (res == '0)));
      // R5
      logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && fsel[2]) |=> !carry);
      // R2
      add_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && fsel == 3'b000) |=>
          ({carry, res} == ({1'b0, $past(opa)} + {1'b0, $past(opb)})));
    end
  endgenerate
endmodule

bind opsel_alu opsel_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb),
  .fsel(fsel), .res(res), .carry(carry), .zero(zero), .out_vld(out_vld)
);

// File: tb/sim_opsel_alu.sv
`timescale 1ns/1ps
module sim_opsel_alu;
  localparam int W = 8;
  localparam int M = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [2:0]   fsel = '0;
  logic [W-1:0] res;
  logic         carry, zero, out_vld;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  // model state
  int    e_res = 0, e_c = 0, e_z = 0, e_v = 0;
  string e_tag = "R1";

  always #2.5 clk = ~clk;

  opsel_alu #(.W(W)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .opa(opa), .opb(opb),
    .fsel(fsel), .res(res), .carry(carry), .zero(zero), .out_vld(out_vld)
  );

  function automatic string tag_of(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      default: return "R6";
    endcase
  endfunction

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    int a, b, s, r, c;
    if (rst) begin
      e_res = 0; e_c = 0; e_z = 0; e_v = 0; e_tag = "R1";
    end else begin
      e_v = in_vld;
      if (in_vld) begin
        a = opa; b = opb; c = 0;
        case (fsel)
          3'd0: begin s = a + b; r = s & M; c = s >> W; end
          3'd1: begin r = (a - b) & M; c = (a >= b) ? 1 : 0; end
          3'd2: begin s = a + 1; r = s & M; c = s >> W; end
          3'd3: begin s = b + 1; r = s & M; c = s >> W; end
          3'd4: r = a & b;
          3'd5: r = a | b;
          3'd6: r = a ^ b;
          default: r = (~a) & M;
        endcase
        e_res = r; e_c = c; e_z = (r == 0) ? 1 : 0;
        e_tag = tag_of(fsel);
      end else begin
        e_tag = "R9";
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check(int'(res) == e_res, e_tag, res, e_res);
      check(int'(carry) == e_c, e_tag, carry, e_c);
      check(int'(zero) == e_z, (e_tag == "R1") ? "R1" : "R7", zero, e_z);
      check(int'(out_vld) == e_v, (e_tag == "R1") ? "R1" : "R8", out_vld, e_v);
    end
  end

  task automatic drive(input bit v, input int op, input int a, input int b);
    @(posedge clk); #1;
    in_vld = v; fsel = op[2:0]; opa = a[W-1:0]; opb = b[W-1:0];
  endtask

  initial begin
    @(posedge clk);
    started = 1;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    // R2 wrap to zero, no carry zero case
    drive(1, 0, 0, 0);
    drive(1, 0, M, 1);
    drive(1, 0, 100, 27);
    // R3 equal, a<b, a>b
    drive(1, 1, 55, 55);
    drive(1, 1, 3, 200);
    drive(1, 1, 200, 3);
    // R4 increment wrap on each operand
    drive(1, 2, M, 7);
    drive(1, 3, 9, M);
    drive(1, 2, 41, 0);
    drive(1, 3, 0, 0);
    // R5 / R6 logic with zero results
    drive(1, 4, 8'hF0, 8'h0F);
    drive(1, 5, 0, 0);
    drive(1, 5, 8'hA0, 8'h05);
    drive(1, 6, 8'h5A, 8'h5A);
    drive(1, 7, M, 0);
    drive(1, 7, 8'h3C, M);
    // R9 gap with changing inputs
    drive(0, 0, M, M);
    drive(0, 1, 1, 2);
    drive(0, 7, 0, 0);
    // random traffic
    for (int i = 0; i < 600; i++)
      drive(($urandom % 4) != 0, $urandom % 8, $urandom % (M + 1), $urandom % (M + 1));
    // R1 reset in mid-flight
    drive(1, 0, M, M);
    @(posedge clk); #1 rst = 1; in_vld = 1; fsel = 3'd0; opa = '1; opb = '1;
    @(posedge clk); #1 rst = 0; in_vld = 0;
    for (int i = 0; i < 300; i++)
      drive(($urandom % 3) != 0, $urandom % 8, $urandom % (M + 1), $urandom % (M + 1));
    drive(0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule